// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit

This block is a combinational arithmetic logic unit assembled from identical one-bit slices, replicated to any word width by a parameter. A two-bit operation code is decoded once into four one-hot operation enables. Those enables are shared by every slice. Each slice selects one of four results: the bitwise AND of the operands, their bitwise OR, the complement of the second operand, or the sum bit of a full adder. The adder carries ripple from the least significant slice to the most significant one. The carry into the bottom slice comes from a port, and the carry out of the top slice is driven to a port.

Before an operand reaches the logic or the adder, it passes through per-operand controls. Each operand has an enable that forces it to zero when deasserted. A separate control complements the first operand after its enable has been applied. In ordinary use both enables are 1 and the invert control is 0. With other settings the same datapath produces subtraction, increment, pass-through and constant results without any extra hardware.

Top module: `bitslice_alu`

## Requirements
- R1: With op_sel = 2'b00, result equals the bitwise AND of the conditioned operands. The conditioned first operand is (a gated by ena_a), then XORed with all ones when inv_a = 1. The conditioned second operand is b gated by ena_b.
- R2: With op_sel = 2'b01, result equals the bitwise OR of the conditioned operands.
- R3: With op_sel = 2'b10, result equals the bitwise complement of the conditioned second operand.
- R4: With op_sel = 2'b11, {carry_out, result} equals the (WIDTH+1)-bit sum of the conditioned first operand, the conditioned second operand and carry_in.
- R5: ena_a = 0 forces the first operand to zero before inversion, so ena_a = 0 with inv_a = 1 presents an all-ones first operand.
- R6: ena_b = 0 forces the second operand to zero for every operation.
- R7: For any op_sel other than 2'b11, carry_out is 0.
- R8: With op_sel = 2'b11, ena_a = ena_b = inv_a = 1 and carry_in = 1, result equals (b - a) modulo 2^WIDTH.
- R9: With op_sel = 2'b11, ena_a = 0, inv_a = 0, ena_b = 1 and carry_in = 1, result equals (b + 1) modulo 2^WIDTH.
- R10: A carry entering the bottom slice ripples through every slice. An all-ones first operand, a zero second operand and carry_in = 1 give result 0 and carry_out 1.
- R11: For the three logic operations, carry_in has no effect on result or carry_out.
- R12: The operation decoder asserts exactly one of its four enables for every op_sel value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation code: 00 AND, 01 OR, 10 NOT second operand, 11 SUM |
| ena_a | input | 1 | First operand enable; 0 forces it to zero |
| ena_b | input | 1 | Second operand enable; 0 forces it to zero |
| inv_a | input | 1 | Complement the gated first operand |
| carry_in | input | 1 | Carry into the least significant slice |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Selected operation result |
| carry_out | output | 1 | Carry out of the most significant slice (SUM only) |

## Verification
Operand conditioning and operation selection act in the same evaluation. One vector therefore tests the enable gating, the inversion and the chosen function at once. The bench drives every combination of op_sel, the two enables, inversion and carry_in with random operands. It also drives directed vectors for subtraction, increment and a full-length carry ripple, where conditioning and the adder interact. Each output is compared against a model, built from the requirements, that first applies the gating and inversion and then the selected function. Logic operations are repeated with both carry_in values. The checks confirm that the carry neither reaches the result nor escapes to carry_out.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_NOTB = 2'b10,
        OP_SUM  = 2'b11
    } alu_op_e;

    localparam int NUM_OPS = 4;

    typedef struct packed {
        logic use_a;
        logic use_b;
        logic flip_a;
    } opnd_ctrl_t;

    typedef struct packed {
        logic en_sum;
        logic en_notb;
        logic en_or;
        logic en_and;
    } op_en_t;

    typedef struct packed {
        logic res;
        logic cout;
    } slice_out_t;

    function automatic op_en_t decode_op(input alu_op_e op);
        op_en_t en;
        en = '0;
        unique case (op)
            OP_AND:  en.en_and  = 1'b1;
            OP_OR:   en.en_or   = 1'b1;
            OP_NOTB: en.en_notb = 1'b1;
            OP_SUM:  en.en_sum  = 1'b1;
            default: en = '0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/alu_decoder.sv
module alu_decoder
    import alu_pkg::*;
(
    input  logic [1:0] op_sel,
    output op_en_t     op_en
);

    always_comb begin
        op_en = decode_op(alu_op_e'(op_sel));
    end

endmodule

// File: rtl/alu_half_adder.sv
module alu_half_adder (
    input  logic x,
    input  logic y,
    output logic s,
    output logic c
);

    assign s = x ^ y;
    assign c = x & y;

endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);

    logic s_lo;
    logic c_lo;
    logic c_hi;

    alu_half_adder u_ha_lo (
        .x (x),
        .y (y),
        .s (s_lo),
        .c (c_lo)
    );

    alu_half_adder u_ha_hi (
        .x (s_lo),
        .y (ci),
        .s (s),
        .c (c_hi)
    );

    assign co = c_lo | c_hi;

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  opnd_ctrl_t ctrl,
    input  op_en_t     op_en,
    input  logic       cin,
    output slice_out_t out
);

    logic a_g;
    logic b_g;
    logic t_and;
    logic t_or;
    logic t_notb;
    logic fa_s;
    logic fa_co;

    // operand conditioning: gate first, then optional complement of A
    assign a_g = (a_bit & ctrl.use_a) ^ ctrl.flip_a;
    assign b_g = b_bit & ctrl.use_b;

    assign t_and  = a_g & b_g;
    assign t_or   = a_g | b_g;
    assign t_notb = ~b_g;

    // adder inputs are gated by the sum enable so the chain is idle otherwise
    alu_full_adder u_fa (
        .x  (a_g & op_en.en_sum),
        .y  (b_g & op_en.en_sum),
        .ci (cin & op_en.en_sum),
        .s  (fa_s),
        .co (fa_co)
    );

    always_comb begin
        out.res  = (op_en.en_and  & t_and)
                 | (op_en.en_or   & t_or)
                 | (op_en.en_notb & t_notb)
                 | (op_en.en_sum  & fa_s);
        out.cout = fa_co;
    end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       op_sel,
    input  logic             ena_a,
    input  logic             ena_b,
    input  logic             inv_a,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int CHAIN_LEN = WIDTH + 1;

    op_en_t           op_en;
    opnd_ctrl_t       ctrl;
    logic [CHAIN_LEN-1:0] carry;

    alu_decoder u_dec (
        .op_sel (op_sel),
        .op_en  (op_en)
    );

    assign ctrl.use_a  = ena_a;
    assign ctrl.use_b  = ena_b;
    assign ctrl.flip_a = inv_a;

    assign carry[0] = carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        slice_out_t so;
        alu_slice u_slice (
            .a_bit (a[i]),
            .b_bit (b[i]),
            .ctrl  (ctrl),
            .op_en (op_en),
            .cin   (carry[i]),
            .out   (so)
        );
        assign result[i]  = so.res;
        assign carry[i+1] = so.cout;
    end

    assign carry_out = carry[WIDTH];

endmodule

// File: rtl/bitslice_alu_checker.sv
module bitslice_alu_checker
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [1:0]       op_sel,
    input logic             ena_a,
    input logic             ena_b,
    input logic             inv_a,
    input logic             carry_in,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input op_en_t           op_en
);

    logic [WIDTH-1:0] ca;
    logic [WIDTH-1:0] cb;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        ca = (ena_a ? a : '0) ^ {WIDTH{inv_a}};
        cb = ena_b ? b : '0;
        wide_sum = {1'b0, ca} + {1'b0, cb} + {{WIDTH{1'b0}}, carry_in};

        // R12
        dec_onehot_chk: assert ($onehot(op_en))
            else $error("decoder enables not one-hot");
        // R7
        idle_carry_chk: assert (op_sel == 2'b11 || carry_out == 1'b0)
            else $error("carry_out set during logic op");
        // R1
        and_result_chk: assert (op_sel != 2'b00 || result == (ca & cb))
            else $error("AND result mismatch");
        // R3
        notb_result_chk: assert (op_sel != 2'b10 || result == ~cb)
            else $error("NOT B result mismatch");
        // R4
        sum_result_chk: assert (op_sel != 2'b11 || {carry_out, result} == wide_sum)
            else $error("SUM result mismatch");
    end

endmodule

bind bitslice_alu bitslice_alu_checker #(.WIDTH(WIDTH)) u_chk (
    .op_sel    (op_sel),
    .ena_a     (ena_a),
    .ena_b     (ena_b),
    .inv_a     (inv_a),
    .carry_in  (carry_in),
    .a         (a),
    .b         (b),
    .result    (result),
    .carry_out (carry_out),
    .op_en     (op_en)
);

// File: tb/sim_bitslice_alu.sv
module sim_bitslice_alu;

    localparam int  WIDTH      = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 50000;

    typedef struct {
        logic [WIDTH-1:0] res;
        logic             co;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       op_sel = '0;
    logic             ena_a = 1'b0;
    logic             ena_b = 1'b0;
    logic             inv_a = 1'b0;
    logic             carry_in = 1'b0;
    logic [WIDTH-1:0] a = '0;
    logic [WIDTH-1:0] b = '0;
    logic [WIDTH-1:0] result;
    logic             carry_out;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bitslice_alu #(.WIDTH(WIDTH)) u0 (
        .op_sel    (op_sel),
        .ena_a     (ena_a),
        .ena_b     (ena_b),
        .inv_a     (inv_a),
        .carry_in  (carry_in),
        .a         (a),
        .b         (b),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic exp_t model(input logic [1:0] op, input logic ea, input logic eb,
                                   input logic ia, input logic ci,
                                   input logic [WIDTH-1:0] va, input logic [WIDTH-1:0] vb,
                                   input string tag);
        exp_t e;
        logic [WIDTH-1:0] pa;
        logic [WIDTH-1:0] pb;
        logic [WIDTH:0]   s;
        pa = ea ? va : '0;
        if (ia) pa = ~pa;
        pb = eb ? vb : '0;
        e.co = 1'b0;
        case (op)
            2'b00: e.res = pa & pb;
            2'b01: e.res = pa | pb;
            2'b10: e.res = ~pb;
            default: begin
                s = {1'b0, pa} + {1'b0, pb} + {{WIDTH{1'b0}}, ci};
                e.res = s[WIDTH-1:0];
                e.co  = s[WIDTH];
            end
        endcase
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input logic [1:0] op, input logic ea, input logic eb,
                         input logic ia, input logic ci,
                         input logic [WIDTH-1:0] va, input logic [WIDTH-1:0] vb,
                         input exp_t e);
        @(posedge clk);
        #1;
        op_sel = op; ena_a = ea; ena_b = eb; inv_a = ia; carry_in = ci; a = va; b = vb;
        sb_q.push_back(e);
    endtask

    task automatic drive_m(input logic [1:0] op, input logic ea, input logic eb,
                           input logic ia, input logic ci,
                           input logic [WIDTH-1:0] va, input logic [WIDTH-1:0] vb,
                           input string tag);
        drive(op, ea, eb, ia, ci, va, vb, model(op, ea, eb, ia, ci, va, vb, tag));
    endtask

    function automatic string tag_of(input logic [1:0] op, input logic ea, input logic eb,
                                     input logic ci);
        if (!eb) return "R6";
        if (!ea) return "R5";
        case (op)
            2'b00: return ci ? "R11" : "R1";
            2'b01: return ci ? "R11" : "R2";
            2'b10: return ci ? "R11" : "R3";
            default: return "R4";
        endcase
    endfunction

    // monitor: sample away from the edge that changes inputs
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (result !== e.res || carry_out !== e.co) begin
                errors++;
                $display("FAIL %s: result=%h carry_out=%b expected result=%h carry_out=%b",
                         e.tag, result, carry_out, e.res, e.co);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset state: all inputs zero -> AND of zeros, no carry (R1, R7)
        e.res = '0; e.co = 1'b0; e.tag = "R1";
        drive(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, e);

        // R8: b - a via inverted A plus carry
        e.res = 8'd37; e.co = 1'b1; e.tag = "R8";
        drive(2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'd63, 8'd100, e);
        e.res = 8'hF6; e.co = 1'b0; e.tag = "R8";
        drive(2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'd20, 8'd10, e);

        // R9: increment of B
        e.res = 8'd42; e.co = 1'b0; e.tag = "R9";
        drive(2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 8'hAA, 8'd41, e);
        e.res = 8'h00; e.co = 1'b1; e.tag = "R9";
        drive(2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 8'h55, 8'hFF, e);

        // R10: full-length ripple
        e.res = 8'h00; e.co = 1'b1; e.tag = "R10";
        drive(2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, e);

        // R5: disabled then inverted A is all ones (OR shows it directly)
        e.res = 8'hFF; e.co = 1'b0; e.tag = "R5";
        drive(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h12, e);

        // R6: NOT of a disabled B is all ones
        e.res = 8'hFF; e.co = 1'b0; e.tag = "R6";
        drive(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hA5, e);

        // R7 and R11: logic ops with carry_in set, carry_out stays 0
        e.res = 8'h0F; e.co = 1'b0; e.tag = "R7";
        drive(2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h0F, e);
        e.res = 8'hFF; e.co = 1'b0; e.tag = "R11";
        drive(2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 8'hF0, 8'h0F, e);

        // R2, R3 directed
        e.res = 8'hF5; e.co = 1'b0; e.tag = "R2";
        drive(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'hF0, 8'h05, e);
        e.res = 8'h5A; e.co = 1'b0; e.tag = "R3";
        drive(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hA5, e);

        // R12 and exhaustive control sweep with random operands
        for (int ctl = 0; ctl < 64; ctl++) begin
            for (int k = 0; k < 12; k++) begin
                logic [1:0] op;
                logic [WIDTH-1:0] ra;
                logic [WIDTH-1:0] rb;
                op = ctl[1:0];
                ra = WIDTH'($urandom);
                rb = WIDTH'($urandom);
                drive_m(op, ctl[2], ctl[3], ctl[4], ctl[5], ra, rb,
                        tag_of(op, ctl[2], ctl[3], ctl[5]));
            end
        end

        // R11: same logic inputs, both carry_in values
        for (int op = 0; op < 3; op++) begin
            drive_m(2'(op), 1'b1, 1'b1, 1'b0, 1'b0, 8'h6C, 8'h93, "R11");
            drive_m(2'(op), 1'b1, 1'b1, 1'b0, 1'b1, 8'h6C, 8'h93, "R11");
        end

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule